// File: doc/BRIEF.md
# Burst Address Sequencer (Linear / Interleaved)

This block generates the low-order address bits that walk a memory through a four-beat synchronous burst. The upper address bits are registered elsewhere. A controller captures a start value through either of two active-low address strobes. After that, each clock edge with the active-low advance enable asserted moves the output one beat further through the burst.

A static select input chooses the stepping rule. With the select low, the output counts upward from the start value and wraps modulo four. With the select high, the output is the start value XORed with the number of beats taken. Board logic normally ties the select high, which gives the interleaved order.

Deasserting advance suspends the burst at the current beat for as many cycles as needed. After four advances the output is back at its start value and the pattern repeats. The block sees only the strobes and the advance enable. A read whose data drivers are switched off still steps the sequence exactly like any other advance.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no strobe or advance, `addr_out` is 00.
- R2: A low `strobe_a_n` at a clock edge captures `start_addr`. From that edge `addr_out` equals the captured value in either order, and the beat count restarts at zero.
- R3: A low `strobe_b_n` alone loads the start value exactly as `strobe_a_n` does. Both strobes low together also load.
- R4: With `seq_lin_n` = 0, each advance edge (`adv_n` = 0, both strobes high) sets `addr_out` to the previous value plus one, modulo 4. For example, start 01 gives 01, 10, 11, 00.
- R5: With `seq_lin_n` = 1, `addr_out` equals the start value XOR the two-bit beat count. Start 01 gives 01, 00, 11, 10; start 11 gives 11, 10, 01, 00; start 10 gives 10, 11, 00, 01.
- R6: An edge with `adv_n` = 1 and both strobes high leaves `addr_out` unchanged, for any number of cycles. A later advance continues from the held beat.
- R7: After four advances since a load, `addr_out` is back at the loaded start value. The same four-value pattern then repeats in both orders.
- R8: When a strobe and `adv_n` = 0 coincide at an edge, the load wins and `addr_out` shows the new start value, not that value plus one step.
- R9: A load may be made at every edge. Each consecutive edge shows its own start value, whichever strobe makes the load.
- R10: `seq_lin_n` acts on the output without a clock. Changing it between edges re-maps the current beat at once, with no change to the start value or the beat count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe_a_n | input | 1 | First address strobe, active low: loads `start_addr` |
| strobe_b_n | input | 1 | Second address strobe, active low: loads `start_addr` |
| start_addr | input | BEAT_W (2) | Start value of the burst |
| adv_n | input | 1 | Advance enable, active low |
| seq_lin_n | input | 1 | Order select: 0 = linear, 1 = interleaved |
| addr_out | output | BEAT_W (2) | Current low-order burst address |

## Verification
The hardest situations to reach are the wrap back to the start value in the interleaved order after a burst has been suspended part-way, and a load that lands on the same edge as an advance. The stimulus reaches them with directed bursts for several start values in each order. It inserts runs of held advance mid-burst, and it loads on advance edges and on every consecutive edge with alternating strobes. A long stretch of random strobes, advances and order changes follows, compared each cycle with a behavioural model of start value and beat count.

// File: rtl/burst_pkg.sv
package burst_pkg;

   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } burst_order_e;

   localparam int unsigned BEAT_W_MIN = 1;
   localparam int unsigned BEAT_W_MAX = 8;

endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
   parameter int unsigned BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BEAT_W-1:0] start_in,
   output logic [BEAT_W-1:0] start_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         start_q <= '0;
      else if (load)
         start_q <= start_in;
   end

endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
   parameter int unsigned BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   output logic [BEAT_W-1:0] beat_q
);

   localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

   // load has priority over step; the count wraps naturally modulo 2**BEAT_W
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         beat_q <= '0;
      else if (load)
         beat_q <= '0;
      else if (step)
         beat_q <= beat_q + ONE;
   end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_pkg::*;
#(
   parameter int unsigned BEAT_W = 2
) (
   input  logic [BEAT_W-1:0] start_q,
   input  logic [BEAT_W-1:0] beat_q,
   input  burst_order_e      order,
   output logic [BEAT_W-1:0] addr
);

   logic [BEAT_W-1:0] lin_addr;
   logic [BEAT_W-1:0] ilv_addr;

   // linear: modular sum of start and beat count
   assign lin_addr = start_q + beat_q;

   // interleaved: each bit flips independently with its beat-count bit
   for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv_bit
      assign ilv_addr[b] = start_q[b] ^ beat_q[b];
   end

   always_comb begin
      unique case (order)
         ORD_LINEAR:     addr = lin_addr;
         ORD_INTERLEAVE: addr = ilv_addr;
         default:        addr = ilv_addr;
      endcase
   end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_pkg::*;
#(
   parameter int unsigned BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe_a_n,
   input  logic              strobe_b_n,
   input  logic [BEAT_W-1:0] start_addr,
   input  logic              adv_n,
   input  logic              seq_lin_n,
   output logic [BEAT_W-1:0] addr_out
);

   if (BEAT_W < BEAT_W_MIN || BEAT_W > BEAT_W_MAX) begin : g_bad_width
      $error("burst_addr_gen: BEAT_W out of supported range");
   end

   logic              load;
   logic              step;
   burst_order_e      order;
   logic [BEAT_W-1:0] start_q;
   logic [BEAT_W-1:0] beat_q;

   assign load  = ~(strobe_a_n & strobe_b_n);
   assign step  = ~adv_n;
   assign order = seq_lin_n ? ORD_INTERLEAVE : ORD_LINEAR;

   burst_start_reg #(.BEAT_W(BEAT_W)) u_start (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .start_in (start_addr),
      .start_q  (start_q)
   );

   burst_beat_cnt #(.BEAT_W(BEAT_W)) u_beat (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .step   (step),
      .beat_q (beat_q)
   );

   burst_order_map #(.BEAT_W(BEAT_W)) u_map (
      .start_q (start_q),
      .beat_q  (beat_q),
      .order   (order),
      .addr    (addr_out)
   );

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
   parameter int unsigned BEAT_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              strobe_a_n,
   input logic              strobe_b_n,
   input logic [BEAT_W-1:0] start_addr,
   input logic              adv_n,
   input logic              seq_lin_n,
   input logic [BEAT_W-1:0] addr_out
);

   logic              chk_load;
   logic [BEAT_W-1:0] chk_start;
   logic [BEAT_W-1:0] chk_beats;

   assign chk_load = !strobe_a_n || !strobe_b_n;

   // shadow of the last loaded start and advances counted since then
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_start <= '0;
         chk_beats <= '0;
      end else if (chk_load) begin
         chk_start <= start_addr;
         chk_beats <= '0;
      end else if (!adv_n) begin
         chk_beats <= chk_beats + BEAT_W'(1);
      end
   end

   assert_reset_zero_R1: assert property (@(posedge clk)
      !rst_n |-> addr_out == '0);

   assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
      chk_load |=> addr_out == $past(start_addr));

   assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!chk_load && !adv_n && !seq_lin_n) |=>
         (!seq_lin_n -> addr_out == $past(addr_out) + BEAT_W'(1)));

   assert_interleave_R5: assert property (@(posedge clk) disable iff (!rst_n)
      seq_lin_n |-> addr_out == (chk_start ^ chk_beats));

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!chk_load && adv_n) |=> ($stable(seq_lin_n) -> $stable(addr_out)));

   assert_wrap_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      chk_beats == '0 |-> addr_out == chk_start);

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.BEAT_W(BEAT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .strobe_a_n (strobe_a_n),
   .strobe_b_n (strobe_b_n),
   .start_addr (start_addr),
   .adv_n      (adv_n),
   .seq_lin_n  (seq_lin_n),
   .addr_out   (addr_out)
);

// File: tb/test_burst_addr_gen.sv
`timescale 1ns/1ps
module test_burst_addr_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       strobe_a_n = 1'b1;
   logic       strobe_b_n = 1'b1;
   logic [1:0] start_addr = 2'b00;
   logic       adv_n = 1'b1;
   logic       seq_lin_n = 1'b1;
   logic [1:0] addr_out;

   int checks = 0;
   int errors = 0;
   string cur_tag = "R1";

   // behavioural reference state
   int ref_start = 0;
   int ref_beats = 0;

   always #10 clk = ~clk;

   burst_addr_gen i_burst_addr_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe_a_n (strobe_a_n),
      .strobe_b_n (strobe_b_n),
      .start_addr (start_addr),
      .adv_n      (adv_n),
      .seq_lin_n  (seq_lin_n),
      .addr_out   (addr_out)
   );

   function automatic int ref_value(input int s, input int n, input logic ilv);
      if (ilv) return s ^ (n % 4);
      return (s + n) % 4;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_start = 0;
         ref_beats = 0;
      end else if (!strobe_a_n || !strobe_b_n) begin
         ref_start = int'(start_addr);
         ref_beats = 0;
      end else if (!adv_n) begin
         ref_beats = ref_beats + 1;
      end
   end

   // every-cycle comparison against the model, away from the rising edge
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (int'(addr_out) != ref_value(ref_start, ref_beats, seq_lin_n)) begin
            errors++;
            $display("FAIL %s model: addr_out=%0d expected=%0d", cur_tag,
                     addr_out, ref_value(ref_start, ref_beats, seq_lin_n));
         end
      end
   end

   task automatic expect_addr(input logic [1:0] exp, input string tag);
      checks++;
      if (addr_out !== exp) begin
         errors++;
         $display("FAIL %s: addr_out=%b expected=%b", tag, addr_out, exp);
      end
   endtask

   // apply inputs for one rising edge; return just after the next falling edge
   task automatic cyc(input logic sa, input logic sb, input logic [1:0] st,
                      input logic adv, input logic ord);
      strobe_a_n = sa;
      strobe_b_n = sb;
      start_addr = st;
      adv_n      = adv;
      seq_lin_n  = ord;
      @(negedge clk);
      #2;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1 reset
      cur_tag = "R1";
      repeat (3) @(negedge clk);
      #2;
      expect_addr(2'b00, "R1 during reset");
      rst_n = 1'b1;
      cyc(1, 1, 2'b11, 1, 0);
      expect_addr(2'b00, "R1 after release");

      // R2 load via A, then R4 linear steps and R7 wrap
      cur_tag = "R2";
      cyc(0, 1, 2'b01, 1, 0);
      expect_addr(2'b01, "R2 load A");
      cur_tag = "R4";
      cyc(1, 1, 2'b00, 0, 0); expect_addr(2'b10, "R4 beat1");
      cyc(1, 1, 2'b00, 0, 0); expect_addr(2'b11, "R4 beat2");
      cyc(1, 1, 2'b00, 0, 0); expect_addr(2'b00, "R4 beat3");
      cur_tag = "R7";
      cyc(1, 1, 2'b00, 0, 0); expect_addr(2'b01, "R7 linear wrap");
      cyc(1, 1, 2'b00, 0, 0); expect_addr(2'b10, "R7 linear repeat");

      // R6 suspend and resume
      cur_tag = "R6";
      for (int i = 0; i < 3; i++) begin
         cyc(1, 1, 2'b11, 1, 0);
         expect_addr(2'b10, "R6 hold");
      end
      cyc(1, 1, 2'b00, 0, 0); expect_addr(2'b11, "R6 resume");

      // R3 load via B, R5 interleaved from 11 with a suspension, R7 wrap
      cur_tag = "R3";
      cyc(1, 0, 2'b11, 1, 1); expect_addr(2'b11, "R3 load B");
      cur_tag = "R5";
      cyc(1, 1, 2'b00, 0, 1); expect_addr(2'b10, "R5 ilv11 beat1");
      cyc(1, 1, 2'b00, 1, 1); expect_addr(2'b10, "R6 ilv hold");
      cyc(1, 1, 2'b00, 0, 1); expect_addr(2'b01, "R5 ilv11 beat2");
      cyc(1, 1, 2'b00, 0, 1); expect_addr(2'b00, "R5 ilv11 beat3");
      cur_tag = "R7";
      cyc(1, 1, 2'b00, 0, 1); expect_addr(2'b11, "R7 interleaved wrap");

      // R5 start 01 and 10, R3 both strobes
      cur_tag = "R5";
      cyc(0, 0, 2'b01, 1, 1); expect_addr(2'b01, "R3 both strobes");
      cyc(1, 1, 2'b00, 0, 1); expect_addr(2'b00, "R5 ilv01 beat1");
      cyc(1, 1, 2'b00, 0, 1); expect_addr(2'b11, "R5 ilv01 beat2");
      cyc(1, 1, 2'b00, 0, 1); expect_addr(2'b10, "R5 ilv01 beat3");
      cyc(0, 1, 2'b10, 1, 1); expect_addr(2'b10, "R5 ilv10 load");
      cyc(1, 1, 2'b00, 0, 1); expect_addr(2'b11, "R5 ilv10 beat1");
      cyc(1, 1, 2'b00, 0, 1); expect_addr(2'b00, "R5 ilv10 beat2");

      // R8 load beats advance on the same edge
      cur_tag = "R8";
      cyc(0, 1, 2'b10, 0, 0); expect_addr(2'b10, "R8 load with advance");
      cyc(1, 1, 2'b00, 0, 0); expect_addr(2'b11, "R8 following step");
      cyc(1, 0, 2'b00, 0, 1); expect_addr(2'b00, "R8 load B with advance");

      // R9 load every edge, alternating strobes
      cur_tag = "R9";
      cyc(0, 1, 2'b11, 0, 0); expect_addr(2'b11, "R9 load 11");
      cyc(1, 0, 2'b01, 0, 0); expect_addr(2'b01, "R9 load 01");
      cyc(0, 1, 2'b10, 0, 1); expect_addr(2'b10, "R9 load 10");
      cyc(1, 0, 2'b00, 1, 1); expect_addr(2'b00, "R9 load 00");

      // R10 order select re-maps current beat without a clock
      cur_tag = "R10";
      cyc(0, 1, 2'b01, 1, 0);
      cyc(1, 1, 2'b00, 0, 0); expect_addr(2'b10, "R10 linear beat1");
      seq_lin_n = 1'b1;
      #1 expect_addr(2'b00, "R10 switched to interleaved");
      seq_lin_n = 1'b0;
      #1 expect_addr(2'b10, "R10 switched back to linear");

      // random stretch, compared by the model each cycle
      cur_tag = "R6 random";
      for (int i = 0; i < 400; i++) begin
         logic [7:0] r;
         r = 8'($urandom);
         cyc(r[0] | r[1], r[2] | r[3], r[5:4], r[6], (i % 37) < 18 ? 1'b1 : 1'b0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule